// File: doc/BRIEF.md
# Priority Interrupt Controller with Sticky Event Flags

This block gathers single-cycle event pulses from a set of peripheral sources and turns them into one interrupt request with a vector for a small CPU. Every source owns a sticky flag that captures its event whatever the mask holds. A mask register decides which captured flags compete for service. A fixed-priority selector then picks the lowest-numbered competitor. A global enable input gates the final request.

Software removes flags by writing ones to a clear port, and rewrites the mask through a separate write port. The CPU signals that it has taken the interrupt with a one-cycle acknowledge. The acknowledge retires only the flag of the source whose vector was on the output in that cycle. Because capture ignores the mask, an event that arrives while its source is masked is not lost. The source starts competing as soon as software unmasks it.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A 1 on `src_evt[i]` at a rising clock edge sets flag i for the following cycle, whether or not mask bit i is set.
- R2: A set flag stays set until a clear write or an acknowledge removes it. Writing 0 into its mask bit does not remove it.
- R3: When `clr_we` is 1 at an edge, each flag whose `clr_data` bit is 1 is cleared and every other flag keeps its value. If an event and a clear hit the same bit in the same cycle, the flag ends up set.
- R4: A source competes only while both its flag and its mask bit are 1. A mask write (`mask_we`=1) loads `mask_wdata` at the edge, and the new mask applies from the next cycle.
- R5: `irq_req` is 1 exactly when `gie` is 1 and at least one source competes. `gie` acts in the same cycle, with no register in its path.
- R6: Among the competing sources, the lowest index wins. While `irq_req` is 1, `irq_vec` equals 4*(i+1) for winning source i, so source 0 gives 8'h04 and source 7 gives 8'h20.
- R7: While `irq_req` is 0, `irq_vec` is 8'h00.
- R8: `ack`=1 at an edge while `irq_req` is 1 clears only the flag of the source shown on `irq_vec` in that cycle. `ack` while `irq_req` is 0 changes nothing. An event on the acknowledged source in the same cycle leaves its flag set.
- R9: During and right after reset (`rst_n`=0, active low), all flags and all mask bits are 0 and `irq_req` is 0.
- R10: A request appears on any of three paths. An event on an unmasked source raises it from the next cycle. A mask write that unmasks an already set flag raises it from the next cycle. A rise of `gie` while some source competes raises it in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_evt | input | NUM_SRC | Single-cycle event pulses, one per source |
| clr_we | input | 1 | Clear write strobe |
| clr_data | input | NUM_SRC | Write-1-to-clear flag bits |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | NUM_SRC | New mask value |
| gie | input | 1 | Global interrupt enable |
| ack | input | 1 | CPU acknowledge pulse |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | VEC_W | Low byte of the service address for the winning source |

## Verification
The properties assume that `ack` is only meaningful while `irq_req` is high, and that the vector on the output identifies the source being acknowledged. They check flag retention only when neither the clear port nor the acknowledge addresses that bit. The stimulus drives all inputs at the falling edge and holds them for a full cycle. Random acknowledges, clears and mask writes are mixed with sparse events, so every combination of event, clear and acknowledge on the same bit occurs while each input still changes only between edges.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
   // Service address low byte for a source index
   function automatic int unsigned vec_of(input int unsigned idx, input int unsigned step);
      return (idx + 1) * step;
   endfunction

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int NUM_SRC = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] evt,
   input  logic               clr_we,
   input  logic [NUM_SRC-1:0] clr_data,
   input  logic [NUM_SRC-1:0] ack_hit,
   output logic [NUM_SRC-1:0] flags
);
   for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_flag
      logic drop;
      assign drop = (clr_we & clr_data[gi]) | ack_hit[gi];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            flags[gi] <= 1'b0;
         else if (evt[gi])
            flags[gi] <= 1'b1;   // event wins over any drop
         else if (drop)
            flags[gi] <= 1'b0;
      end
   end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
   parameter int NUM_SRC = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [NUM_SRC-1:0] wdata,
   output logic [NUM_SRC-1:0] mask
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mask <= '0;
      else if (we)
         mask <= wdata;
   end
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
   parameter int NUM_SRC = 8,
   parameter int IDX_W   = 3
) (
   input  logic [NUM_SRC-1:0] compete,
   output logic               any,
   output logic [IDX_W-1:0]   idx,
   output logic [NUM_SRC-1:0] grant
);
   always_comb begin
      any   = 1'b0;
      idx   = '0;
      grant = '0;
      // scan from the top so the lowest index is the last to overwrite
      for (int k = NUM_SRC - 1; k >= 0; k--) begin
         if (compete[k]) begin
            any   = 1'b1;
            idx   = IDX_W'(k);
            grant = NUM_SRC'(1) << k;
         end
      end
   end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
   parameter int NUM_SRC  = 8,
   parameter int VEC_W    = 8,
   parameter int VEC_STEP = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_evt,
   input  logic               clr_we,
   input  logic [NUM_SRC-1:0] clr_data,
   input  logic               mask_we,
   input  logic [NUM_SRC-1:0] mask_wdata,
   input  logic               gie,
   input  logic               ack,
   output logic               irq_req,
   output logic [VEC_W-1:0]   irq_vec
);
   import irq_prio_pkg::*;

   localparam int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
   localparam int MAX_VEC = NUM_SRC * VEC_STEP;

   initial begin
      if (NUM_SRC < 1)
         $fatal(1, "irq_prio_ctrl: NUM_SRC must be at least 1");
      if (VEC_STEP < 1)
         $fatal(1, "irq_prio_ctrl: VEC_STEP must be at least 1");
      if (VEC_W <= IDX_W || MAX_VEC > (2 ** VEC_W) - 1)
         $fatal(1, "irq_prio_ctrl: VEC_W too narrow for the vector range");
   end

   logic [NUM_SRC-1:0] posted_q;
   logic [NUM_SRC-1:0] mask_q;
   logic [NUM_SRC-1:0] compete;
   logic [NUM_SRC-1:0] grant;
   logic [NUM_SRC-1:0] ack_hit;
   logic [IDX_W-1:0]   win_idx;
   logic               any_comp;
   logic [VEC_W-1:0]   win_vec;

   irq_flag_bank #(.NUM_SRC(NUM_SRC)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (src_evt),
      .clr_we   (clr_we),
      .clr_data (clr_data),
      .ack_hit  (ack_hit),
      .flags    (posted_q)
   );

   irq_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (mask_we),
      .wdata (mask_wdata),
      .mask  (mask_q)
   );

   assign compete = posted_q & mask_q;

   irq_prio_sel #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_sel (
      .compete (compete),
      .any     (any_comp),
      .idx     (win_idx),
      .grant   (grant)
   );

   // vector arithmetic: shift when the step is a power of two, else multiply
   if (is_pow2(VEC_STEP)) begin : g_vec_shift
      localparam int SH = $clog2(VEC_STEP);
      assign win_vec = (VEC_W'(win_idx) + VEC_W'(1)) << SH;
   end else begin : g_vec_mul
      assign win_vec = (VEC_W'(win_idx) + VEC_W'(1)) * VEC_W'(VEC_STEP);
   end

   assign irq_req = gie & any_comp;
   assign irq_vec = irq_req ? win_vec : '0;
   assign ack_hit = (ack & irq_req) ? grant : '0;
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
   parameter int NUM_SRC  = 8,
   parameter int VEC_W    = 8,
   parameter int VEC_STEP = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] src_evt,
   input logic               clr_we,
   input logic [NUM_SRC-1:0] clr_data,
   input logic               mask_we,
   input logic [NUM_SRC-1:0] mask_wdata,
   input logic               gie,
   input logic               ack,
   input logic               irq_req,
   input logic [VEC_W-1:0]   irq_vec,
   input logic [NUM_SRC-1:0] posted_q,
   input logic [NUM_SRC-1:0] mask_q
);
   for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_bit
      localparam logic [VEC_W-1:0] VEC_I = VEC_W'((gi + 1) * VEC_STEP);

      assert_evt_posts_R1: assert property (@(posedge clk) disable iff (!rst_n)
         src_evt[gi] |=> posted_q[gi]);

      assert_flag_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
         posted_q[gi] && !(clr_we && clr_data[gi]) && !(ack && irq_req && irq_vec == VEC_I)
         |=> posted_q[gi]);

      assert_clear_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
         clr_we && clr_data[gi] && !src_evt[gi] |=> !posted_q[gi]);

      assert_ack_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
         ack && irq_req && irq_vec == VEC_I && !src_evt[gi] |=> !posted_q[gi]);

      assert_lowest_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
         irq_req && posted_q[gi] && mask_q[gi] |-> irq_vec <= VEC_I);
   end

   assert_mask_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mask_we |=> mask_q == $past(mask_wdata));

   assert_gie_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !gie |-> !irq_req);

   assert_pending_raises_R5: assert property (@(posedge clk) disable iff (!rst_n)
      gie && (|(posted_q & mask_q)) |-> irq_req);

   assert_idle_vec_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_req |-> irq_vec == '0);
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
   .NUM_SRC (NUM_SRC),
   .VEC_W   (VEC_W),
   .VEC_STEP(VEC_STEP)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .src_evt   (src_evt),
   .clr_we    (clr_we),
   .clr_data  (clr_data),
   .mask_we   (mask_we),
   .mask_wdata(mask_wdata),
   .gie       (gie),
   .ack       (ack),
   .irq_req   (irq_req),
   .irq_vec   (irq_vec),
   .posted_q  (posted_q),
   .mask_q    (mask_q)
);

// File: tb/irq_prio_ctrl_bench.sv
`timescale 1ns/1ps
module irq_prio_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] src_evt = '0;
   logic       clr_we = 1'b0;
   logic [7:0] clr_data = '0;
   logic       mask_we = 1'b0;
   logic [7:0] mask_wdata = '0;
   logic       gie = 1'b0;
   logic       ack = 1'b0;
   logic       irq_req;
   logic [7:0] irq_vec;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   // reference state
   bit [7:0] m_post = '0;
   bit [7:0] m_mask = '0;

   always #2 clk = ~clk;

   irq_prio_ctrl u_irq_prio_ctrl (
      .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .clr_we(clr_we),
      .clr_data(clr_data), .mask_we(mask_we), .mask_wdata(mask_wdata),
      .gie(gie), .ack(ack), .irq_req(irq_req), .irq_vec(irq_vec)
   );

   task automatic compare(input string tag, input bit exp_req, input bit [7:0] exp_vec);
      n_cmp++;
      if (irq_req !== exp_req || irq_vec !== exp_vec) begin
         n_bad++;
         $display("FAIL %s: req=%0b vec=%02h expected req=%0b vec=%02h",
                  tag, irq_req, irq_vec, exp_req, exp_vec);
      end
   endtask

   // one clock: drive at the falling edge, compare, then advance the model
   task automatic step(input string tag, input bit [7:0] evt, input bit cw,
                       input bit [7:0] cd, input bit mw, input bit [7:0] md,
                       input bit g, input bit a);
      bit       e_req;
      bit [7:0] e_vec;
      int       win;
      bit [7:0] nxt;
      @(negedge clk);
      src_evt = evt; clr_we = cw; clr_data = cd;
      mask_we = mw; mask_wdata = md; gie = g; ack = a;
      #1;
      win = -1;
      for (int k = 7; k >= 0; k--)
         if (m_post[k] && m_mask[k]) win = k;
      e_req = g && (win >= 0);
      e_vec = e_req ? 8'((win + 1) * 4) : 8'h00;
      compare(tag, e_req, e_vec);
      nxt = m_post;
      if (a && e_req) nxt[win] = 1'b0;
      if (cw) nxt = nxt & ~cd;
      nxt = nxt | evt;
      @(posedge clk);
      m_post = nxt;
      if (mw) m_mask = md;
   endtask

   initial begin
      gie = 1'b1;
      repeat (3) @(negedge clk);
      #1 compare("R9 in reset", 1'b0, 8'h00);
      rst_n = 1'b1;
      step("R9 after reset", 8'h00, 0, 8'h00, 0, 8'h00, 1, 0);
      // masked source still posts
      step("R1 masked event", 8'h08, 0, 8'h00, 0, 8'h00, 1, 0);
      step("R4 masked no req", 8'h00, 0, 8'h00, 0, 8'h00, 1, 0);
      step("R10 unmask write", 8'h00, 0, 8'h00, 1, 8'h08, 1, 0);
      step("R10 unmask raises", 8'h00, 0, 8'h00, 0, 8'h00, 1, 0);
      step("R5 gie low", 8'h00, 0, 8'h00, 0, 8'h00, 0, 0);
      step("R10 gie rise", 8'h00, 0, 8'h00, 0, 8'h00, 1, 0);
      // remask keeps the flag
      step("R2 remask", 8'h00, 0, 8'h00, 1, 8'h00, 1, 0);
      step("R2 masked hold", 8'h00, 0, 8'h00, 1, 8'hFF, 1, 0);
      step("R2 flag kept", 8'h81, 0, 8'h00, 0, 8'h00, 1, 0);
      step("R6 lowest wins", 8'h00, 0, 8'h00, 0, 8'h00, 1, 1);
      step("R8 ack retires src0", 8'h00, 0, 8'h00, 0, 8'h00, 1, 1);
      step("R8 ack retires src3", 8'h00, 0, 8'h00, 0, 8'h00, 1, 0);
      step("R3 event beats clear", 8'h80, 1, 8'h80, 0, 8'h00, 1, 0);
      step("R3 still set", 8'h00, 1, 8'h7F, 0, 8'h00, 1, 0);
      step("R3 clear zero bits", 8'h00, 1, 8'h80, 0, 8'h00, 1, 0);
      step("R7 idle vector", 8'h04, 0, 8'h00, 0, 8'h00, 0, 1);
      step("R8 ack ignored gie0", 8'h00, 0, 8'h00, 0, 8'h00, 0, 1);
      step("R8 flag survived", 8'h04, 0, 8'h00, 0, 8'h00, 1, 1);
      step("R8 event beats ack", 8'h00, 0, 8'h00, 0, 8'h00, 1, 0);
      step("R10 event raises", 8'h00, 1, 8'hFF, 0, 8'h00, 1, 0);
      step("R10 clean", 8'h02, 0, 8'h00, 0, 8'h00, 1, 0);
      step("R10 unmasked event", 8'h00, 0, 8'h00, 0, 8'h00, 1, 0);
      for (int i = 0; i < 600; i++) begin
         bit [7:0] ev;
         ev = (($urandom % 4) == 0) ? 8'(1 << ($urandom % 8)) : 8'h00;
         step("R6 random", ev, ($urandom % 8) == 0, 8'($urandom),
              ($urandom % 10) == 0, 8'($urandom), ($urandom % 5) != 0,
              ($urandom % 3) == 0);
      end
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule